// File: doc/BRIEF.md
# Supply-Good and Pushbutton Reset Sequencer

This block drives the active-low system reset of a chip region. Two things can cause a reset. One is a digital supply-good flag, which comes from an analog comparator outside the block. The other is an active-low pushbutton input that is not synchronised to the clock. The pushbutton path is brought into the clock domain and has to stay low for a minimum number of cycles before it counts, so short negative spikes are ignored. Once every cause has gone away, the reset stays asserted for a fixed stretch of clock cycles and then releases.

The block also drives a watchdog-clear level for a companion windowed watchdog. This level is high while the reset is busy, and it rises one cycle before the reset itself when a pushbutton press is accepted. The watchdog therefore clears its interval timer and drops its fault pulse. The watchdog fault output may be looped back into the pushbutton input. Each release of that input restarts the whole stretch, so even a short fault pulse produces a full-length reset.

A three-state machine controls the sequence:
- HOLD: a cause is active.
- STRETCH: the timeout is counting.
- RUN: the reset is released.

The transitions are:
- cause-clear: HOLD to STRETCH.
- cause-return: STRETCH to HOLD, which reloads the count.
- stretch-done: STRETCH to RUN.
- cause-hit: RUN to HOLD.

At power-up the machine sits in HOLD with all counters at zero.

Top module: `pwr_rst_gen`

## Requirements
- R1: While `pwr_ok_i` is 0, `rst_n_o` is 0 from the first clock edge after the flag falls (one register of latency).
- R2: A press on `mr_n_i` (0 = pressed) that is low across at least MR_MIN_CYC consecutive clock edges is accepted. After 2 synchroniser edges and MR_MIN_CYC filter edges, counted from the first low edge k, the watchdog clear rises after edge k+MR_MIN_CYC+1 and `rst_n_o` falls after edge k+MR_MIN_CYC+2.
- R3: A press low across fewer than MR_MIN_CYC edges has no effect: `rst_n_o` stays 1 and `wdt_clr_o` stays 0.
- R4: When `pwr_ok_i` rises with no press held, first seen at edge e, `rst_n_o` stays 0 through edge e+TIMEOUT_CYC-1 and is 1 after edge e+TIMEOUT_CYC.
- R5: A release of an accepted press, first high at edge r, restarts the full stretch: `rst_n_o` is 1 only after edge r+3+TIMEOUT_CYC.
- R6: A cause that returns at any point of the stretch, including its last cycle, sends the machine back to HOLD. The full TIMEOUT_CYC count is then required again after the next release.
- R7: At power-up, before the first clock edge, `rst_n_o` is 0 and `wdt_clr_o` is 1.
- R8: `wdt_clr_o` is 1 in every cycle in which `rst_n_o` is 0, and also in the cycle in which a press is accepted.
- R9: The two causes combine as an OR. A supply dip while a press is held does not shorten the stretch: the release time follows the later of the two causes to clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| pwr_ok_i | input | 1 | Supply-good flag, 1 = supply within limits, synchronous to clk |
| mr_n_i | input | 1 | Pushbutton reset, active low, asynchronous |
| rst_n_o | output | 1 | System reset, active low |
| wdt_clr_o | output | 1 | Watchdog clear, high while reset busy or a press is accepted |

## Verification
The bench builds the block with MR_MIN_CYC = 4 and TIMEOUT_CYC = 12. These values make every press width from 1 to 7 cycles cheap to sweep, covering both sides of the acceptance threshold and the exact-threshold case. They also make it cheap to return a supply dip at every one of the twelve stretch offsets, the final cycle included. Each sweep point predicts the output cycle by cycle from the latencies in the requirements. One extra pass checks that overlapping causes combine as an OR.

// File: rtl/pwr_rst_pkg.sv
package pwr_rst_pkg;

    typedef enum logic [1:0] {
        PG_HOLD    = 2'd0,
        PG_STRETCH = 2'd1,
        PG_RUN     = 2'd2
    } pg_state_e;

endpackage

// File: rtl/pwr_rst_sync.sv
module pwr_rst_sync #(
    parameter int STAGES   = 2,
    parameter bit INIT_VAL = 1'b1
) (
    input  logic clk,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q = {STAGES{INIT_VAL}};

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) chain_q <= d_i;
        end else begin : g_multi
            always_ff @(posedge clk) chain_q <= {chain_q[STAGES-2:0], d_i};
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pwr_rst_filter.sv
module pwr_rst_filter #(
    parameter int MIN_CYC = 50
) (
    input  logic clk,
    input  logic low_i,
    output logic accepted_o
);
    localparam int FW = $clog2(MIN_CYC + 1);
    localparam logic [FW-1:0] SAT = FW'(MIN_CYC);

    logic [FW-1:0] run_q = '0;
    logic          armed_q = 1'b0;

    always_ff @(posedge clk) begin
        armed_q <= 1'b1;
        if (!low_i)
            run_q <= '0;
        else if (run_q != SAT)
            run_q <= run_q + 1'b1;
    end

    assign accepted_o = (run_q == SAT);

    // R2: the low-time counter saturates and never passes the threshold
    assert_filter_sat_R2: assert property (@(posedge clk) disable iff (!armed_q)
        run_q <= SAT);

    // R3: a high synchronised level withdraws acceptance on the next edge
    assert_release_drops_R3: assert property (@(posedge clk) disable iff (!armed_q)
        !low_i |=> !accepted_o);
endmodule

// File: rtl/pwr_rst_fsm.sv
module pwr_rst_fsm
    import pwr_rst_pkg::*;
#(
    parameter int TIMEOUT_CYC = 9_000_000
) (
    input  logic clk,
    input  logic cause_i,
    output logic rst_n_o,
    output logic busy_o
);
    localparam int CW = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    pg_state_e     state_q = PG_HOLD;
    pg_state_e     state_d;
    logic [CW-1:0] cnt_q = '0;
    logic          armed_q = 1'b0;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PG_HOLD:    if (!cause_i) state_d = PG_STRETCH;
            PG_STRETCH: begin
                if (cause_i)            state_d = PG_HOLD;
                else if (cnt_q == LAST) state_d = PG_RUN;
            end
            PG_RUN:     if (cause_i) state_d = PG_HOLD;
            default:    state_d = PG_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        armed_q <= 1'b1;
        state_q <= state_d;
        if (state_q == PG_STRETCH && state_d == PG_STRETCH)
            cnt_q <= cnt_q + 1'b1;
        else
            cnt_q <= '0;
    end

    always_comb begin
        rst_n_o = (state_q == PG_RUN);
        busy_o  = (state_q != PG_RUN);
    end

    // R1: any cause holds reset low from the next edge
    assert_cause_low_R1: assert property (@(posedge clk) disable iff (!armed_q)
        cause_i |=> !rst_n_o);

    // R4: release only follows a complete stretch
    assert_full_stretch_R4: assert property (@(posedge clk) disable iff (!armed_q)
        $rose(rst_n_o) |-> ($past(state_q) == PG_STRETCH && $past(cnt_q) == LAST));

    // R4: stretch counter stays inside the timeout window
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!armed_q)
        cnt_q <= LAST);

    // R6: a returning cause during the stretch reloads via HOLD
    assert_reload_R6: assert property (@(posedge clk) disable iff (!armed_q)
        (state_q == PG_STRETCH && cause_i) |=> (state_q == PG_HOLD && cnt_q == '0));
endmodule

// File: rtl/pwr_rst_gen.sv
module pwr_rst_gen #(
    parameter int SYNC_STAGES = 2,
    parameter int MR_MIN_CYC  = 50,
    parameter int TIMEOUT_CYC = 9_000_000
) (
    input  logic clk,
    input  logic pwr_ok_i,
    input  logic mr_n_i,
    output logic rst_n_o,
    output logic wdt_clr_o
);
    logic mr_n_s;
    logic mr_acc;
    logic cause;
    logic busy;
    logic armed_q = 1'b0;

    always_ff @(posedge clk) armed_q <= 1'b1;

    pwr_rst_sync #(.STAGES(SYNC_STAGES), .INIT_VAL(1'b1)) u_sync (
        .clk (clk),
        .d_i (mr_n_i),
        .q_o (mr_n_s)
    );

    pwr_rst_filter #(.MIN_CYC(MR_MIN_CYC)) u_filter (
        .clk        (clk),
        .low_i      (!mr_n_s),
        .accepted_o (mr_acc)
    );

    assign cause = !pwr_ok_i || mr_acc;

    pwr_rst_fsm #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_fsm (
        .clk     (clk),
        .cause_i (cause),
        .rst_n_o (rst_n_o),
        .busy_o  (busy)
    );

    assign wdt_clr_o = busy || mr_acc;

    // R8: watchdog is held clear whenever reset is asserted
    assert_clr_covers_rst_R8: assert property (@(posedge clk) disable iff (!armed_q)
        !rst_n_o |-> wdt_clr_o);

    // R2: an accepted press pulls reset low on the following edge
    assert_press_resets_R2: assert property (@(posedge clk) disable iff (!armed_q)
        mr_acc |=> !rst_n_o);
endmodule

// File: tb/pwr_rst_gen_tb_top.sv
module pwr_rst_gen_tb_top;
    localparam int M = 4;
    localparam int T = 12;

    logic clk = 1'b0;
    logic pwr_ok_i;
    logic mr_n_i;
    logic rst_n_o;
    logic wdt_clr_o;
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    always #10 clk = ~clk;

    pwr_rst_gen #(.SYNC_STAGES(2), .MR_MIN_CYC(M), .TIMEOUT_CYC(T)) dut_i (
        .clk       (clk),
        .pwr_ok_i  (pwr_ok_i),
        .mr_n_i    (mr_n_i),
        .rst_n_o   (rst_n_o),
        .wdt_clr_o (wdt_clr_o)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s at %0t: got %b expected %b", req, what, $time, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, got hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        pwr_ok_i = 1'b0;
        mr_n_i   = 1'b1;
        #1;
        // R7: power-up state before any edge
        chk("R7", "rst_n", rst_n_o, 1'b0);
        chk("R7", "wdt_clr", wdt_clr_o, 1'b1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R1", "rst_n", rst_n_o, 1'b0);
        end

        // R4: supply rise, exact stretch
        pwr_ok_i = 1'b1;
        for (int i = 0; i <= T; i++) begin
            @(negedge clk);
            chk("R4", "rst_n", rst_n_o, logic'(i == T));
            chk("R8", "wdt_clr", wdt_clr_o, logic'(i != T));
        end

        // R2 R3 R5 R8: press-width sweep across the threshold
        for (int w = 1; w <= M + 3; w++) begin
            mr_n_i = 1'b0;
            for (int i = 0; i <= w + T + 5; i++) begin
                logic acc, e_rst, e_clr;
                @(negedge clk);
                acc   = (w >= M);
                e_rst = !(acc && i >= M + 2 && i <= w + 2 + T);
                e_clr = acc && i >= M + 1 && i <= w + 2 + T;
                chk(acc ? "R2/R5" : "R3", "rst_n", rst_n_o, e_rst);
                chk(acc ? "R8" : "R3", "wdt_clr", wdt_clr_o, e_clr);
                if (i == w - 1) mr_n_i = 1'b1;
            end
        end

        // R6: supply dip at each stretch offset, last cycle included
        for (int j = 0; j < T; j++) begin
            pwr_ok_i = 1'b0;
            @(negedge clk);
            chk("R1", "rst_n", rst_n_o, 1'b0);
            pwr_ok_i = 1'b1;
            for (int i = 0; i <= j + 2 + T; i++) begin
                @(negedge clk);
                chk("R6", "rst_n", rst_n_o, logic'(i == j + 2 + T));
                if (i == j)     pwr_ok_i = 1'b0;
                if (i == j + 1) pwr_ok_i = 1'b1;
            end
        end

        // R9: supply dip while a press is held, then press release
        mr_n_i = 1'b0;
        repeat (M + 4) @(negedge clk);
        chk("R9", "rst_n", rst_n_o, 1'b0);
        pwr_ok_i = 1'b0;
        repeat (3) @(negedge clk);
        pwr_ok_i = 1'b1;
        for (int i = 0; i < T + 3; i++) begin
            @(negedge clk);
            chk("R9", "rst_n held by press", rst_n_o, 1'b0);
        end
        mr_n_i = 1'b1;
        for (int i = 0; i <= T + 3; i++) begin
            @(negedge clk);
            chk("R5/R9", "rst_n", rst_n_o, logic'(i == T + 3));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule